// File: doc/BRIEF.md
# Quadratic Warp Source Address Generator

This block walks a destination rectangle one pixel per clock, row by row. For each target pixel it works out where to read in the source image. The source coordinate comes from a second-order polynomial in the pixel's offset from the rectangle's top-left corner, so the block covers panning, zooming, rotation and mild warps. The polynomial is evaluated with running forward differences, so the datapath holds only adders. Each pixel yields four results:

- a registered 12-bit integer source address;
- an 8-bit coefficient-table address, built from the high fraction bits of this axis and four fraction bits supplied by the partner axis;
- the registered target column;
- a flag that says whether the source address falls inside a programmable read window.

One instance handles one source axis. A second instance with its own coefficients produces the other axis.

Parameters are written one at a time into a shadow bank through a 4-bit addressed, 12-bit data port. A single load strobe then copies the whole bank into the working set, so a new transform can be staged while the current one runs. A start pulse begins a walk. A done flag marks the last pixel and holds until the next start. The target-port drive enable is brought out as a plain signal rather than a three-state pad.

Top module: `warp_addr_gen`

## Requirements
- R1: After reset, `src_addr`, `coef_addr`, `tgt_addr`, `in_win`, `pix_valid`, `done` and `tgt_drive` are all 0.
- R2: At a rising edge with `prm_wr_n` low, `prm_data` is stored into the shadow register selected by `prm_addr`. With `prm_wr_n` high, no shadow register changes.
- R3: At a rising edge with `prm_load` high, all shadow registers are copied into the working set at once. If a write happens at the same edge, the value copied is the one held before that write. While `prm_load` is low, the working set keeps its values.
- R4: Shadow address map:
  - 0: u² coefficient A (signed, weight 2^-16)
  - 1: u coefficient B (signed, weight 2^-8)
  - 2: uv coefficient C (signed, weight 2^-16)
  - 3: v² coefficient D (signed, weight 2^-16)
  - 4: v coefficient E (signed, weight 2^-8)
  - 5: origin F (unsigned integer)
  - 6, 7: source window low and high
  - 8, 9: first and last column
  - 10, 11: first and last row

  Writes to addresses 12 to 15 change nothing.
- R5: When `start` is sampled high, the walk restarts at (first column, first row). The rising edge that follows presents that pixel with `pix_valid` high. After that, one pixel is presented per edge: columns ascend to the last column, then the next row begins, through the last row, both bounds inclusive.
- R6: For a pixel at offsets du = u − first column and dv = v − first row, let X = A·du² + B·du + C·du·dv + D·dv² + E·dv + F, kept exactly modulo 2^28 with 16 fraction bits. `src_addr` is bits 27..16 of X and `tgt_addr` is u.
- R7: `coef_addr[7:4]` is bits 15..12 of X. `coef_addr[3:0]` is `y_frac` as sampled on the same edge that presents the pixel.
- R8: `in_win` is 1 exactly when `pix_valid` is 1 and window low ≤ `src_addr` ≤ window high (unsigned). Otherwise it is 0.
- R9: `done` rises together with the last pixel of the rectangle and stays high until `start` is sampled. A `start` sampled during a walk abandons it: no pixel is presented on that edge, and the following edge presents the new first pixel.
- R10: `tgt_drive` equals the inverse of `tgt_oe_n` as sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| prm_data | input | 12 | Shadow register write data |
| prm_addr | input | 4 | Shadow register select |
| prm_wr_n | input | 1 | Shadow write enable, active low |
| prm_load | input | 1 | Copy shadow bank into working set |
| start | input | 1 | Begin (or restart) a walk |
| y_frac | input | 4 | Fraction nibble from the partner axis |
| tgt_oe_n | input | 1 | Target port output enable, active low |
| src_addr | output | 12 | Integer source address |
| coef_addr | output | 8 | Interpolation coefficient address |
| tgt_addr | output | 12 | Target column |
| in_win | output | 1 | Source address inside read window |
| pix_valid | output | 1 | A pixel is presented this cycle |
| done | output | 1 | Last pixel reached, held until start |
| tgt_drive | output | 1 | Target port drive enable |

## Verification
Four coefficient sets are compared against a direct evaluation of the polynomial, so any drift in the difference accumulators shows up:
- An error in the 2A or 2D second differences gives a source address that drifts quadratically along a row or down the rectangle.
- Using the old uv term when a new row begins shifts every row after the first.

One set makes the integer part wrap past 4095, which exposes a saturating or mis-sized accumulator. The window is placed so that both of its edges fall inside a walk, which exposes off-by-one comparisons.

Directed cases cover the shadow and working banks:
- a write with the enable high, which a faulty design would store;
- a write and a load on the same edge, where a faulty design would forward the new word;
- writes to unused addresses, which a faulty design would alias onto the origin.

A start in mid-walk checks that no stale pixel leaks out before the restart.

// File: rtl/warp_pkg.sv
package warp_pkg;
  localparam int CW     = 12;           // coordinate / parameter word
  localparam int AW     = 4;            // shadow address width
  localparam int FRAC   = 16;           // accumulator fraction bits
  localparam int ACC_W  = CW + FRAC;    // accumulator width
  localparam int LIN_SH = 8;            // extra shift for first-order terms
  localparam int NIB    = 4;            // fraction nibble per axis
  localparam int NREG   = 12;           // implemented shadow registers

  localparam int IX_A = 0, IX_B = 1, IX_C = 2, IX_D = 3, IX_E = 4, IX_F = 5;
  localparam int IX_XLO = 6, IX_XHI = 7, IX_ULO = 8, IX_UHI = 9;
  localparam int IX_VLO = 10, IX_VHI = 11;

  typedef logic [CW-1:0]           word_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    word_t a, b, c, d, e, f;
    word_t xlo, xhi, ulo, uhi, vlo, vhi;
  } xform_t;

  // second-order weight: 2^-16
  function automatic acc_t quad_w(input word_t w);
    return acc_t'($signed(w));
  endfunction

  // first-order weight: 2^-8
  function automatic acc_t lin_w(input word_t w);
    return acc_t'($signed(w)) <<< LIN_SH;
  endfunction

  // integer origin
  function automatic acc_t org_w(input word_t w);
    return acc_t'({w, {FRAC{1'b0}}});
  endfunction

  function automatic logic in_window(input word_t v, input word_t lo, input word_t hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/warp_prm_bank.sv
module warp_prm_bank
  import warp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_n,
  input  logic [AW-1:0] addr,
  input  word_t       data,
  input  logic        load,
  output xform_t      act
);
  logic [NREG-1:0][CW-1:0] pre_q;
  logic [NREG-1:0][CW-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (!wr_n && (addr == AW'(i))) pre_q[i] <= data;
      end
      if (load) act_q <= pre_q;
    end
  end

  assign act.a   = act_q[IX_A];
  assign act.b   = act_q[IX_B];
  assign act.c   = act_q[IX_C];
  assign act.d   = act_q[IX_D];
  assign act.e   = act_q[IX_E];
  assign act.f   = act_q[IX_F];
  assign act.xlo = act_q[IX_XLO];
  assign act.xhi = act_q[IX_XHI];
  assign act.ulo = act_q[IX_ULO];
  assign act.uhi = act_q[IX_UHI];
  assign act.vlo = act_q[IX_VLO];
  assign act.vhi = act_q[IX_VHI];

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(pre_q));
  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
endmodule

// File: rtl/warp_scan.sv
module warp_scan
  import warp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  word_t ulo,
  input  word_t uhi,
  input  word_t vlo,
  input  word_t vhi,
  output logic  run,
  output word_t u,
  output logic  row_end,
  output logic  last
);
  logic  run_q;
  word_t u_q, v_q;

  assign run     = run_q;
  assign u       = u_q;
  assign row_end = run_q && (u_q >= uhi);
  assign last    = row_end && (v_q >= vhi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      u_q   <= '0;
      v_q   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      u_q   <= ulo;
      v_q   <= vlo;
    end else if (run_q) begin
      if (row_end) begin
        u_q <= ulo;
        if (last) run_q <= 1'b0;
        else      v_q   <= v_q + word_t'(1);
      end else begin
        u_q <= u_q + word_t'(1);
      end
    end
  end
endmodule

// File: rtl/warp_poly.sv
module warp_poly
  import warp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   init,
  input  logic   step,
  input  logic   row_end,
  input  xform_t prm,
  output word_t  x_int,
  output logic [NIB-1:0] x_nib
);
  acc_t x_q, row_q, rd_q, ud_q, cdv_q;
  acc_t qa, qc, qd, row_n, cdv_n;

  assign qa    = quad_w(prm.a);
  assign qc    = quad_w(prm.c);
  assign qd    = quad_w(prm.d);
  assign row_n = row_q + rd_q;
  assign cdv_n = cdv_q + qc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; row_q <= '0; rd_q <= '0; ud_q <= '0; cdv_q <= '0;
    end else if (init) begin
      x_q   <= org_w(prm.f);
      row_q <= org_w(prm.f);
      rd_q  <= qd + lin_w(prm.e);
      cdv_q <= '0;
      ud_q  <= qa + lin_w(prm.b);
    end else if (step) begin
      if (row_end) begin
        row_q <= row_n;
        x_q   <= row_n;
        rd_q  <= rd_q + qd + qd;
        cdv_q <= cdv_n;
        ud_q  <= qa + lin_w(prm.b) + cdv_n;
      end else begin
        x_q  <= x_q + ud_q;
        ud_q <= ud_q + qa + qa;
      end
    end
  end

  assign x_int = x_q[ACC_W-1:FRAC];
  assign x_nib = x_q[FRAC-1 -: NIB];
endmodule

// File: rtl/warp_addr_gen.sv
module warp_addr_gen
  import warp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] prm_data,
  input  logic [3:0]  prm_addr,
  input  logic        prm_wr_n,
  input  logic        prm_load,
  input  logic        start,
  input  logic [3:0]  y_frac,
  input  logic        tgt_oe_n,
  output logic [11:0] src_addr,
  output logic [7:0]  coef_addr,
  output logic [11:0] tgt_addr,
  output logic        in_win,
  output logic        pix_valid,
  output logic        done,
  output logic        tgt_drive
);
  xform_t prm;
  logic   run, row_end, last;
  word_t  u, x_int;
  logic [NIB-1:0] x_nib;
  logic   emit;

  warp_prm_bank i_bank (
    .clk(clk), .rst_n(rst_n), .wr_n(prm_wr_n), .addr(prm_addr),
    .data(prm_data), .load(prm_load), .act(prm)
  );

  warp_scan i_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ulo(prm.ulo), .uhi(prm.uhi), .vlo(prm.vlo), .vhi(prm.vhi),
    .run(run), .u(u), .row_end(row_end), .last(last)
  );

  warp_poly i_poly (
    .clk(clk), .rst_n(rst_n), .init(start), .step(run), .row_end(row_end),
    .prm(prm), .x_int(x_int), .x_nib(x_nib)
  );

  assign emit = run && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      coef_addr <= '0;
      tgt_addr  <= '0;
      in_win    <= 1'b0;
      pix_valid <= 1'b0;
      done      <= 1'b0;
      tgt_drive <= 1'b0;
    end else begin
      pix_valid <= emit;
      tgt_drive <= !tgt_oe_n;
      if (start)                done <= 1'b0;
      else if (run && last)     done <= 1'b1;
      if (emit) begin
        src_addr  <= x_int;
        coef_addr <= {x_nib, y_frac};
        tgt_addr  <= u;
        in_win    <= in_window(x_int, prm.xlo, prm.xhi);
      end else begin
        in_win    <= 1'b0;
      end
    end
  end

  // R9
  done_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> pix_valid);
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pix_valid);
  // R8
  win_needs_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> pix_valid);
  // R10
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tgt_drive == !$past(tgt_oe_n)));
endmodule

// File: tb/test_warp_addr_gen.sv
module test_warp_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 4;
  // order: A B C D E F XLO XHI ULO UHI VLO VHI
  localparam logic [11:0] CFG [NCFG][12] = '{
    '{12'h000, 12'h100, 12'h000, 12'h000, 12'h000, 12'd100, 12'd100, 12'd102, 12'd10,  12'd13,  12'd5,   12'd6},
    '{12'h000, 12'h080, 12'h000, 12'h000, 12'hF00, 12'd50,  12'd40,  12'd60,  12'd0,   12'd3,   12'd0,   12'd2},
    '{12'h7FF, 12'h010, 12'h123, 12'hF80, 12'h040, 12'd2000,12'd1990,12'd2010,12'd100, 12'd104, 12'd200, 12'd202},
    '{12'h000, 12'h300, 12'h000, 12'h000, 12'h100, 12'd4090,12'd0,   12'd4,   12'd0,   12'd4,   12'd0,   12'd1}
  };

  logic clk = 0, rst_n = 0;
  logic [11:0] prm_data = 0;
  logic [3:0]  prm_addr = 0, y_frac = 0;
  logic prm_wr_n = 1, prm_load = 0, start = 0, tgt_oe_n = 1;
  logic [11:0] src_addr, tgt_addr;
  logic [7:0]  coef_addr;
  logic in_win, pix_valid, done, tgt_drive;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_addr_gen i_warp_addr_gen (
    .clk(clk), .rst_n(rst_n), .prm_data(prm_data), .prm_addr(prm_addr),
    .prm_wr_n(prm_wr_n), .prm_load(prm_load), .start(start), .y_frac(y_frac),
    .tgt_oe_n(tgt_oe_n), .src_addr(src_addr), .coef_addr(coef_addr),
    .tgt_addr(tgt_addr), .in_win(in_win), .pix_valid(pix_valid), .done(done),
    .tgt_drive(tgt_drive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint model_x(input int k, input int du, input int dv);
    longint a, b, c, d, e, f, x;
    a = longint'($signed(CFG[k][0])); b = longint'($signed(CFG[k][1]));
    c = longint'($signed(CFG[k][2])); d = longint'($signed(CFG[k][3]));
    e = longint'($signed(CFG[k][4])); f = longint'(CFG[k][5]);
    x = a*du*du + b*256*du + c*du*dv + d*dv*dv + e*256*dv + f*65536;
    return x & 64'h0FFF_FFFF;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    prm_addr = a; prm_data = d; prm_wr_n = 0;
    @(negedge clk); prm_wr_n = 1;
  endtask

  task automatic ld();
    prm_load = 1; @(negedge clk); prm_load = 0;
  endtask

  // pulses start; returns at the negedge after the first pixel
  task automatic first_pixel();
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  task automatic run_cfg(input int k);
    int nu, nv, pix;
    longint x;
    logic [11:0] xi;
    for (int r = 0; r < 12; r++) wr(4'(r), CFG[k][r]);
    ld();
    nu = int'(CFG[k][9]) - int'(CFG[k][8]) + 1;
    nv = int'(CFG[k][11]) - int'(CFG[k][10]) + 1;
    start = 1; @(negedge clk); start = 0;
    pix = 0;
    y_frac = 4'((pix*7 + 3) & 15);
    for (int dv = 0; dv < nv; dv++) begin
      for (int du = 0; du < nu; du++) begin
        logic [3:0] yf;
        yf = y_frac;
        @(negedge clk);
        x  = model_x(k, du, dv);
        xi = 12'(x >> 16);
        chk("R5 pix_valid", pix_valid, 1);
        chk("R5 tgt_addr", tgt_addr, CFG[k][8] + 12'(du));
        chk("R6 src_addr", src_addr, xi);
        chk("R7 coef_addr", coef_addr, {4'(x >> 12), yf});
        chk("R8 in_win", in_win, (xi >= CFG[k][6]) && (xi <= CFG[k][7]));
        chk("R9 done", done, (dv == nv-1) && (du == nu-1));
        pix++;
        y_frac = 4'((pix*7 + 3) & 15);
      end
    end
    @(negedge clk);
    chk("R9 idle after last", pix_valid, 0);
    chk("R8 in_win idle", in_win, 0);
    chk("R9 done held", done, 1);
    repeat (3) @(negedge clk);
    chk("R9 done still held", done, 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 src", src_addr, 0); chk("R1 coef", coef_addr, 0);
    chk("R1 tgt", tgt_addr, 0); chk("R1 in_win", in_win, 0);
    chk("R1 valid", pix_valid, 0); chk("R1 done", done, 0);
    chk("R1 drive", tgt_drive, 0);
    rst_n = 1;
    @(negedge clk);

    // R10 drive enable follows one edge later
    tgt_oe_n = 0; #1;
    chk("R10 before edge", tgt_drive, 0);
    @(negedge clk);
    chk("R10 enabled", tgt_drive, 1);
    tgt_oe_n = 1; @(negedge clk);
    chk("R10 disabled", tgt_drive, 0);

    // table of coefficient sets (R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < NCFG; k++) run_cfg(k);

    // R2: write with enable high is ignored
    prm_addr = 4'd5; prm_data = 12'd777; prm_wr_n = 1; @(negedge clk);
    ld();
    first_pixel();
    chk("R2 ignored write", src_addr, 12'd4090);
    drain();

    // R3: no load keeps working set
    wr(4'd5, 12'd300);
    first_pixel();
    chk("R3 no load", src_addr, 12'd4090);
    drain();

    // R3: write and load on one edge copies the old shadow word
    prm_addr = 4'd5; prm_data = 12'd500; prm_wr_n = 0; prm_load = 1;
    @(negedge clk); prm_wr_n = 1; prm_load = 0;
    first_pixel();
    chk("R3 same-edge load", src_addr, 12'd300);
    drain();
    ld();
    first_pixel();
    chk("R3 later load", src_addr, 12'd500);
    drain();

    // R4: unused addresses do not alias
    for (int a = 12; a < 16; a++) wr(4'(a), 12'hFFF);
    ld();
    first_pixel();
    chk("R4 unused addr src", src_addr, 12'd500);
    chk("R4 unused addr tgt", tgt_addr, 12'd0);
    drain();

    // R9: restart mid-walk
    first_pixel();
    @(negedge clk);
    chk("R9 mid-walk column", tgt_addr, 12'd1);
    start = 1; @(negedge clk); start = 0;
    chk("R9 abandoned pixel", pix_valid, 0);
    chk("R9 done cleared", done, 0);
    @(negedge clk);
    chk("R9 restart valid", pix_valid, 1);
    chk("R9 restart column", tgt_addr, 12'd0);
    chk("R9 restart src", src_addr, 12'd500);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule